// File: doc/BRIEF.md
# Slave-Clocked Serial Word Transmitter

This block sends words out on a single data line, one bit per cycle of a serial clock that an external master supplies. The system side loads a word through a one-cycle write strobe into a holding buffer. The word moves into a shift register as soon as the shifter is free. At that moment the block raises a one-cycle interrupt pulse, which tells the host that the buffer can take the next word. The serial clock idles low. Each bit is presented before a rising serial edge, where the master samples it. The line advances to the next bit after the following falling edge.

In continuous mode the host may queue a second word while the first is still shifting. The queued word then follows the current one with no idle serial cycle between them. A status flag stays high from the first accepted write until a word finishes with nothing queued behind it. Word length and bit order are chosen per word. The serial clock passes through a synchronizer and edge detector, so all logic runs on the system clock. Only the transmit direction is built: the block has no receive path and raises no receive-done event.

Top module: `ser_slave_tx`

## Requirements
- R1: After a synchronous reset, `sdo`, `busy` and `txe_irq` are all 0.
- R2: A write (`wr_valid` high) is accepted when `en` and `tx_en` are both high and either `cont_mode` is 1 or `busy` is 0. An accepted write sets `busy` to 1 from the next cycle on.
- R3: Each time a buffered word is moved into the shift register, `txe_irq` is high for exactly one system clock cycle. This gives one pulse per transmitted word.
- R4: With `msb_first`=1 the word of length L is sent as bit L-1 first down to bit 0. With `msb_first`=0 it is sent as bit 0 first up to bit L-1. Data bits at or above L are never sent.
- R5: The first bit of a word appears on `sdo` within a few system cycles of the load. `sdo` changes only after a falling edge of `sclk_in`. Without serial clock edges it holds its value indefinitely.
- R6: `len_code` selects the word length L: code 0 gives 8 bits, and any code k from 1 to 15 gives k bits. A word ends on its L-th falling serial edge. `busy` is still 1 after L-1 falling edges.
- R7: If no word is queued when a word ends, `busy` returns to 0 and transmission stops.
- R8: In continuous mode, a word written while the previous word shifts is placed on `sdo` right after the previous word's last falling edge. `busy` stays 1 across the boundary.
- R9: With `cont_mode`=0, a write made while `busy` is 1 is ignored. That word is never sent and raises no `txe_irq`.
- R10: While `en` or `tx_en` is 0, writes are ignored and serial clock edges have no effect. `sdo` holds its last level and `busy` keeps its value. A word interrupted this way resumes where it stopped once both are high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| tx_en | input | 1 | Transmit enable |
| msb_first | input | 1 | 1: most significant bit first; 0: least significant first |
| cont_mode | input | 1 | 1: words may be queued behind the active word |
| len_code | input | 4 | Word length code (0 = 8 bits, k = k bits) |
| wr_valid | input | 1 | One-cycle write strobe into the buffer |
| wr_data | input | 16 | Word to transmit |
| sclk_in | input | 1 | Serial clock from the external master, idle low |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | A word is queued or being shifted |
| txe_irq | output | 1 | One-cycle pulse: buffer handed to shifter |

## Verification
The bench covers these corner cases:
- **Word boundary.** `busy` is checked one falling edge before the end of a word and again after it. A counter that is off by one would drop `busy` early or leave it stuck high.
- **Back-to-back words.** A second word is queued during the first. A design that inserted a gap, or lost the queued word, would show the wrong bit on `sdo` after the boundary and too few interrupt pulses.
- **Lengths and bit orders.** The vector table spans the 1-bit and 15-bit lengths, both bit orders, and data with set bits above the selected length. A wrong length decode or a wrong alignment would leak those upper bits or reverse the word.
- **Ignored writes and disabled state.** A write is attempted while busy in single mode, and the block is disabled in the middle of a word. A design that accepted those writes or kept shifting would send stray data or lose its place in the word.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic {
    ORD_LSB = 1'b0,
    ORD_MSB = 1'b1
  } bit_order_e;

endpackage

// File: rtl/sst_sclk_sync.sv
module sst_sclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  output logic fall
);

  logic [STAGES:0] chain;
  logic            last_q;

  assign chain[0] = sclk_in;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i+1] <= 1'b0;
      else     chain[i+1] <= chain[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES];
  end

  assign fall = last_q & ~chain[STAGES];

  // R5: a detected falling edge never lasts more than one system cycle
  p_fall_isolated_r5: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);

endmodule

// File: rtl/sst_tx_buffer.sv
module sst_tx_buffer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              cont_mode,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  input  logic              word_end,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_data,
  output logic              busy
);

  logic accept;

  assign accept = active & wr_valid & (cont_mode | ~busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
      buf_data <= '0;
      busy     <= 1'b0;
    end else begin
      if (accept) begin
        buf_data <= wr_data;
        buf_full <= 1'b1;
      end else if (take) begin
        buf_full <= 1'b0;
      end

      if (accept)
        busy <= 1'b1;
      else if (word_end && !buf_full)
        busy <= 1'b0;
    end
  end

  // R2: an accepted write leaves a full buffer and a raised busy flag
  p_write_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && buf_full));

  // R9: in single mode an empty buffer stays empty while busy
  p_single_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (!cont_mode && busy && !buf_full) |=> !buf_full);

  // R7: end of word with nothing queued drops busy
  p_busy_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (word_end && !buf_full && !accept) |=> !busy);

  // R10: a disabled block keeps its busy flag
  p_busy_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (!active && !word_end) |=> $stable(busy));

endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 4,
  parameter int DEF_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              fall,
  input  logic              msb_first,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  output logic              take,
  output logic              word_end,
  output logic              sdo,
  output logic              txe
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] DW_C  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] DEF_C = CNT_W'(DEF_LEN);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  bit_order_e        ord_q;

  logic [CNT_W-1:0]  ld_len;
  logic [CNT_W-1:0]  ld_shamt;
  logic [DATA_W-1:0] ld_sh;
  logic              ld_first;
  logic              step;

  // length decode: code 0 is the default length, any other code is literal
  always_comb begin
    if (len_code == '0) ld_len = DEF_C;
    else                ld_len = CNT_W'(len_code);
    ld_shamt = DW_C - ld_len;
    if (msb_first) begin
      ld_sh    = buf_data << ld_shamt;
      ld_first = ld_sh[DATA_W-1];
    end else begin
      ld_sh    = buf_data;
      ld_first = buf_data[0];
    end
  end

  assign step     = active & run_q & fall;
  assign word_end = step & (cnt_q == ONE_C);
  assign take     = active & buf_full & (~run_q | word_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      ord_q <= ORD_LSB;
      sdo   <= 1'b0;
      txe   <= 1'b0;
    end else begin
      txe <= take;
      if (take) begin
        sh_q  <= ld_sh;
        cnt_q <= ld_len;
        run_q <= 1'b1;
        ord_q <= msb_first ? ORD_MSB : ORD_LSB;
        sdo   <= ld_first;
      end else if (word_end) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (step) begin
        cnt_q <= cnt_q - ONE_C;
        if (ord_q == ORD_MSB) begin
          sh_q <= sh_q << 1;
          sdo  <= sh_q[DATA_W-2];
        end else begin
          sh_q <= sh_q >> 1;
          sdo  <= sh_q[1];
        end
      end
    end
  end

  // R3: the hand-off pulse is a single cycle wide
  p_txe_single_r3: assert property (@(posedge clk) disable iff (rst)
    txe |=> !txe);

  // R6: the remaining-bit count never exceeds the shift register width
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DW_C);

  // R5: without a serial edge or a load, the line holds
  p_sdo_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!fall && !take) |=> $stable(sdo));

  // R10: a disabled block holds its output
  p_hold_when_off_r10: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(sdo));

endmodule

// File: rtl/ser_slave_tx.sv
module ser_slave_tx #(
  parameter int DATA_W      = 16,
  parameter int LEN_W       = 4,
  parameter int DEF_LEN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tx_en,
  input  logic              msb_first,
  input  logic              cont_mode,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sclk_in,
  output logic              sdo,
  output logic              busy,
  output logic              txe_irq
);

  logic              active;
  logic              fall;
  logic              take;
  logic              word_end;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;

  assign active = en & tx_en;

  sst_sclk_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sclk_in (sclk_in),
    .fall    (fall)
  );

  sst_tx_buffer #(
    .DATA_W (DATA_W)
  ) u_buf (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .cont_mode (cont_mode),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .take      (take),
    .word_end  (word_end),
    .buf_full  (buf_full),
    .buf_data  (buf_data),
    .busy      (busy)
  );

  sst_shifter #(
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W),
    .DEF_LEN (DEF_LEN)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .fall      (fall),
    .msb_first (msb_first),
    .len_code  (len_code),
    .buf_full  (buf_full),
    .buf_data  (buf_data),
    .take      (take),
    .word_end  (word_end),
    .sdo       (sdo),
    .txe       (txe_irq)
  );

  // R8: a queued word is loaded on the same edge that ends the current word
  p_back_to_back_r8: assert property (@(posedge clk) disable iff (rst)
    (word_end && buf_full) |=> (busy && txe_irq));

endmodule

// File: tb/ser_slave_tx_bench.sv
`timescale 1ns/1ps
module ser_slave_tx_bench;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0, tx_en = 1'b0, msb_first = 1'b1, cont_mode = 1'b1;
  logic        wr_valid = 1'b0, sclk = 1'b0;
  logic [3:0]  len_code = 4'd0;
  logic [15:0] wr_data = 16'h0;
  logic        sdo, busy, txe;

  int n_chk = 0, n_bad = 0, txe_seen = 0;
  bit done = 0;

  // vector: {len_code, msb_first, data}
  localparam logic [20:0] VEC [0:5] = '{
    {4'd0,  1'b1, 16'h00A5},
    {4'd0,  1'b0, 16'h00A5},
    {4'd3,  1'b1, 16'hFFF5},
    {4'd1,  1'b0, 16'hFFFF},
    {4'd15, 1'b1, 16'hDA3C},
    {4'd12, 1'b0, 16'hFC71}
  };

  always #2.5 clk = ~clk;

  ser_slave_tx u_ser_slave_tx (
    .clk(clk), .rst(rst), .en(en), .tx_en(tx_en), .msb_first(msb_first),
    .cont_mode(cont_mode), .len_code(len_code), .wr_valid(wr_valid),
    .wr_data(wr_data), .sclk_in(sclk), .sdo(sdo), .busy(busy), .txe_irq(txe)
  );

  always @(posedge clk) if (!rst && txe === 1'b1) txe_seen++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_bits(input int n, output logic [31:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      got[k] = sdo;
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
      idle(HALF);
    end
  endtask

  function automatic int len_of(input logic [3:0] c);
    return (c == 4'd0) ? 8 : int'(c);
  endfunction

  function automatic logic [31:0] exp_bits(input logic [15:0] d, input int len, input bit msb);
    logic [31:0] r = '0;
    for (int k = 0; k < len; k++) r[k] = msb ? d[len-1-k] : d[k];
    return r;
  endfunction

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] g1, g2, got;
    int t0, len;
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk(sdo == 1'b0, "R1 sdo", sdo, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(txe_seen == 0, "R1 txe_irq", txe_seen, 0);

    en = 1'b1; tx_en = 1'b1; cont_mode = 1'b1;

    // table walk: R2 R3 R4 R6 R7
    for (int i = 0; i < 6; i++) begin
      len_code  = VEC[i][20:17];
      msb_first = VEC[i][16];
      len = len_of(len_code);
      t0 = txe_seen;
      wr(VEC[i][15:0]);
      idle(3);
      chk(busy == 1'b1, "R2 busy after write", busy, 1);
      chk(txe_seen == t0 + 1, "R3 one pulse per word", txe_seen - t0, 1);
      run_bits(len - 1, g1);
      chk(busy == 1'b1, "R6 busy before last edge", busy, 1);
      run_bits(1, g2);
      got = g1 | (g2 << (len - 1));
      idle(2);
      chk(got == exp_bits(VEC[i][15:0], len, VEC[i][16]), "R4 R6 bit sequence",
          got, exp_bits(VEC[i][15:0], len, VEC[i][16]));
      chk(busy == 1'b0, "R7 busy cleared", busy, 0);
    end

    // R5: line holds without serial edges
    len_code = 4'd0; msb_first = 1'b1;
    wr(16'h0080);
    idle(40);
    chk(sdo == 1'b1, "R5 first bit presented", sdo, 1);
    run_bits(1, g1);
    idle(30);
    chk(sdo == 1'b0, "R5 second bit held", sdo, 0);
    run_bits(7, g1);
    idle(2);

    // R8: continuous back-to-back
    t0 = txe_seen;
    wr(16'h00C3);
    idle(3);
    wr(16'h005A);
    run_bits(8, g1);
    idle(2);
    chk(busy == 1'b1, "R8 busy across boundary", busy, 1);
    chk(txe_seen == t0 + 2, "R8 second hand-off", txe_seen - t0, 2);
    chk(sdo == 1'b0, "R8 next word first bit", sdo, 0);
    run_bits(8, g2);
    idle(2);
    chk(g1 == exp_bits(16'h00C3, 8, 1'b1), "R8 first word", g1, exp_bits(16'h00C3, 8, 1'b1));
    chk(g2 == exp_bits(16'h005A, 8, 1'b1), "R8 second word", g2, exp_bits(16'h005A, 8, 1'b1));
    chk(busy == 1'b0, "R7 busy cleared after pair", busy, 0);

    // R9: single mode ignores writes while busy
    cont_mode = 1'b0;
    t0 = txe_seen;
    wr(16'h0096);
    idle(3);
    wr(16'h0011);
    run_bits(8, g1);
    idle(4);
    chk(g1 == exp_bits(16'h0096, 8, 1'b1), "R9 first word intact", g1, exp_bits(16'h0096, 8, 1'b1));
    chk(busy == 1'b0, "R9 no queued word", busy, 0);
    chk(txe_seen == t0 + 1, "R9 single hand-off", txe_seen - t0, 1);
    cont_mode = 1'b1;

    // R10: disabled block ignores writes
    tx_en = 1'b0;
    t0 = txe_seen;
    wr(16'h00FF);
    idle(3);
    chk(busy == 1'b0, "R10 write ignored", busy, 0);
    chk(txe_seen == t0, "R10 no hand-off", txe_seen - t0, 0);
    tx_en = 1'b1;
    idle(2);
    chk(busy == 1'b0, "R10 nothing queued", busy, 0);

    // R10: freeze mid-word and resume
    wr(16'h00A5);
    idle(3);
    run_bits(2, g1);
    en = 1'b0;
    run_bits(3, g2);
    chk(g2[2:0] == 3'b111, "R10 sdo held while off", g2[2:0], 3'b111);
    chk(busy == 1'b1, "R10 busy kept while off", busy, 1);
    en = 1'b1;
    idle(2);
    run_bits(6, got);
    idle(2);
    chk(got[5:0] == 6'b101001, "R10 word resumed", got[5:0], 6'b101001);
    chk(busy == 1'b0, "R7 busy cleared after resume", busy, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule